// File: doc/BRIEF.md
# Bit-Masked Receive PHY Control Register Bank

This block holds the static and test controls of a camera receive PHY as a small bank of 32-bit registers on a simple memory-mapped bus. Each write carries its own enables: the upper half-word of the write data picks which bits of the lower half-word are updated. Software can therefore change one field, such as one lane's enable bit or the test clock pin, in a single write. It does not have to read the register first or worry that another agent changes a neighbouring field in the meantime.

Three writable registers drive the PHY pins. The first holds the per-lane fields: lane enable, force-receive, force-stop and turnaround disable. The second holds the turnaround request and the two clock-inversion selects. The third holds the test interface: data in, enable, clock and clear. A fourth register is read-only and returns the PHY's 8-bit test data output. The bus takes one transfer per cycle. A write takes effect at the clock edge where `bus_valid` and `bus_write` are both high. Read data is combinational from the address while a read is presented.

Top module: `phy_ctl_bank`

## Requirements
- R1: On a write to a writable register, bit n of the stored lower half-word takes write-data bit n only when write-data bit n+16 is 1. Every bit whose enable is 0 keeps its value. The new value shows on the pins and on reads from the cycle after the write edge.
- R2: The lane control register at offset 0x6254 holds lane enable in bits [3:0], force-receive in [7:4], force-stop in [11:8] and turnaround disable in [15:12]. Each field has one bit per lane, with lane k at the field's bit k.
- R3: The register at offset 0x6224 holds turnaround request in bits [3:0], clock-inversion select 0 at bit 10 and select 1 at bit 11. Its other bits are not stored: they read 0 and writes to them are ignored.
- R4: The test register at offset 0x6264 holds test data in [7:0], test enable at bit 8, test clock at bit 9 and test clear at bit 10. Bits [15:11] read 0 and ignore writes.
- R5: The status register at offset 0xe2a4 reads the current PHY test data output in bits [7:0], with all other bits 0. Writes to it change nothing.
- R6: While a read is presented (`bus_valid` high, `bus_write` low), `bus_rdata` returns the stored lower half-word with bits [31:16] at 0. At all other times `bus_rdata` is 0.
- R7: A write to an unmapped offset changes no register. A read from an unmapped offset returns 0.
- R8: After a synchronous reset every stored bit is 0, except test clock, which is 1.
- R9: A write presented with `bus_valid` low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Transfer strobe |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W (16) | Byte offset of the register |
| bus_wdata | input | 32 | [31:16] bit enables, [15:0] new values |
| bus_rdata | output | 32 | Read data, combinational |
| phy_test_dout | input | 8 | Test data output from the PHY |
| lane_en | output | 4 | Per-lane enable |
| lane_force_rx | output | 4 | Per-lane force-receive |
| lane_force_stop | output | 4 | Per-lane force-stop |
| lane_turn_dis | output | 4 | Per-lane turnaround disable |
| lane_turn_req | output | 4 | Per-lane turnaround request |
| clk_inv_sel | output | 2 | Clock-inversion selects, index 0 and 1 |
| test_din | output | 8 | PHY test data input |
| test_en | output | 1 | PHY test enable |
| test_clk | output | 1 | PHY test clock |
| test_clr | output | 1 | PHY test clear |

## Verification
The bench builds the bank with its default parameters: a 16-bit address, the four offsets above and four lanes. These defaults put the full 16-bit enable half in play, including enables that point at unstored bits of the two sparse registers, and make offsets that differ from a mapped one by a few bits a natural probe for decoding faults. The table of vectors mixes all-ones, all-zeros and single-field masks, so a bit that ignores its enable, or a field wired to the wrong pins, shows up both in readback and at the pins.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;

    localparam int HALF_W  = 16;
    localparam int WORD_W  = 2 * HALF_W;
    localparam int LANES   = 4;
    localparam int TDATA_W = 8;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [WORD_W-1:0] word_t;

    // Register selected by the current bus address
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TURN,
        SEL_LANE,
        SEL_TEST,
        SEL_STAT
    } reg_sel_e;

    // Lane control word, MSB first
    typedef struct packed {
        logic [LANES-1:0] turn_dis;
        logic [LANES-1:0] force_stop;
        logic [LANES-1:0] force_rx;
        logic [LANES-1:0] enable;
    } lane_ctl_t;

    // Turnaround request / clock inversion word
    typedef struct packed {
        logic [3:0]       rsvd_hi;
        logic [1:0]       clk_inv;
        logic [5:0]       rsvd_lo;
        logic [LANES-1:0] req;
    } turn_ctl_t;

    // Test interface word
    typedef struct packed {
        logic [4:0]         rsvd;
        logic               clr;
        logic               tck;
        logic               ten;
        logic [TDATA_W-1:0] din;
    } test_ctl_t;

    // Bits physically stored in each writable word
    localparam half_t LANE_IMPL = 16'hFFFF;
    localparam half_t TURN_IMPL = 16'h0C0F;
    localparam half_t TEST_IMPL = 16'h07FF;

    // Reset images
    localparam half_t LANE_RST = 16'h0000;
    localparam half_t TURN_RST = 16'h0000;
    localparam half_t TEST_RST = 16'h0200;

    // New value of one stored bit under a self-masked write
    function automatic logic masked_bit(input logic cur, input logic din, input logic en);
        return en ? din : cur;
    endfunction

    // Zero-extend a half-word into a bus word
    function automatic word_t widen(input half_t h);
        return {{(WORD_W-HALF_W){1'b0}}, h};
    endfunction

endpackage

// File: rtl/phy_ctl_decode.sv
module phy_ctl_decode
    import phy_ctl_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] OFF_TURN = 16'h6224,
    parameter logic [ADDR_W-1:0] OFF_LANE = 16'h6254,
    parameter logic [ADDR_W-1:0] OFF_TEST = 16'h6264,
    parameter logic [ADDR_W-1:0] OFF_STAT = 16'he2a4
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        unique case (addr)
            OFF_TURN: sel = SEL_TURN;
            OFF_LANE: sel = SEL_LANE;
            OFF_TEST: sel = SEL_TEST;
            OFF_STAT: sel = SEL_STAT;
            default:  sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/phy_ctl_mask_reg.sv
module phy_ctl_mask_reg
    import phy_ctl_pkg::*;
#(
    parameter half_t IMPL    = 16'hFFFF,
    parameter half_t RST_VAL = 16'h0000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  word_t wr_word,
    output half_t q
);

    localparam int N = HALF_W;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (IMPL[i]) begin : g_store
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)
                    bit_q <= RST_VAL[i];
                else if (wr_en)
                    bit_q <= masked_bit(bit_q, wr_word[i], wr_word[i+N]);
            end
            assign q[i] = bit_q;
        end else begin : g_tie
            assign q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/phy_ctl_bank.sv
module phy_ctl_bank
    import phy_ctl_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] OFF_TURN = 16'h6224,
    parameter logic [ADDR_W-1:0] OFF_LANE = 16'h6254,
    parameter logic [ADDR_W-1:0] OFF_TEST = 16'h6264,
    parameter logic [ADDR_W-1:0] OFF_STAT = 16'he2a4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [7:0]         phy_test_dout,
    output logic [3:0]         lane_en,
    output logic [3:0]         lane_force_rx,
    output logic [3:0]         lane_force_stop,
    output logic [3:0]         lane_turn_dis,
    output logic [3:0]         lane_turn_req,
    output logic [1:0]         clk_inv_sel,
    output logic [7:0]         test_din,
    output logic               test_en,
    output logic               test_clk,
    output logic               test_clr
);

    reg_sel_e  sel;
    logic      wr_ok;
    logic      rd_ok;
    half_t     lane_q, turn_q, test_q;
    lane_ctl_t lane_s;
    turn_ctl_t turn_s;
    test_ctl_t test_s;

    phy_ctl_decode #(
        .ADDR_W  (ADDR_W),
        .OFF_TURN(OFF_TURN),
        .OFF_LANE(OFF_LANE),
        .OFF_TEST(OFF_TEST),
        .OFF_STAT(OFF_STAT)
    ) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    assign wr_ok = bus_valid &&  bus_write;
    assign rd_ok = bus_valid && !bus_write;

    phy_ctl_mask_reg #(.IMPL(LANE_IMPL), .RST_VAL(LANE_RST)) u_lane (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_ok && sel == SEL_LANE),
        .wr_word(bus_wdata),
        .q      (lane_q)
    );

    phy_ctl_mask_reg #(.IMPL(TURN_IMPL), .RST_VAL(TURN_RST)) u_turn (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_ok && sel == SEL_TURN),
        .wr_word(bus_wdata),
        .q      (turn_q)
    );

    phy_ctl_mask_reg #(.IMPL(TEST_IMPL), .RST_VAL(TEST_RST)) u_test (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_ok && sel == SEL_TEST),
        .wr_word(bus_wdata),
        .q      (test_q)
    );

    assign lane_s = lane_ctl_t'(lane_q);
    assign turn_s = turn_ctl_t'(turn_q);
    assign test_s = test_ctl_t'(test_q);

    // Pin fan-out
    assign lane_en         = lane_s.enable;
    assign lane_force_rx   = lane_s.force_rx;
    assign lane_force_stop = lane_s.force_stop;
    assign lane_turn_dis   = lane_s.turn_dis;
    assign lane_turn_req   = turn_s.req;
    assign clk_inv_sel     = turn_s.clk_inv;
    assign test_din        = test_s.din;
    assign test_en         = test_s.ten;
    assign test_clk        = test_s.tck;
    assign test_clr        = test_s.clr;

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            unique case (sel)
                SEL_LANE: bus_rdata = widen(lane_q);
                SEL_TURN: bus_rdata = widen(turn_q);
                SEL_TEST: bus_rdata = widen(test_q);
                SEL_STAT: bus_rdata = widen({{(HALF_W-TDATA_W){1'b0}}, phy_test_dout});
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/phy_ctl_bank_chk.sv
module phy_ctl_bank_chk #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] OFF_TURN = 16'h6224,
    parameter logic [ADDR_W-1:0] OFF_LANE = 16'h6254,
    parameter logic [ADDR_W-1:0] OFF_TEST = 16'h6264,
    parameter logic [ADDR_W-1:0] OFF_STAT = 16'he2a4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [7:0]        phy_test_dout,
    input logic [3:0]        lane_en,
    input logic [3:0]        lane_force_rx,
    input logic [3:0]        lane_force_stop,
    input logic [3:0]        lane_turn_dis,
    input logic [3:0]        lane_turn_req,
    input logic [1:0]        clk_inv_sel,
    input logic [7:0]        test_din,
    input logic              test_en,
    input logic              test_clk,
    input logic              test_clr
);

    logic [15:0] lane_w, turn_w, test_w;
    logic        wr_lane, wr_turn, wr_test;

    assign lane_w  = {lane_turn_dis, lane_force_stop, lane_force_rx, lane_en};
    assign turn_w  = {4'b0, clk_inv_sel, 6'b0, lane_turn_req};
    assign test_w  = {5'b0, test_clr, test_clk, test_en, test_din};
    assign wr_lane = bus_valid && bus_write && bus_addr == OFF_LANE;
    assign wr_turn = bus_valid && bus_write && bus_addr == OFF_TURN;
    assign wr_test = bus_valid && bus_write && bus_addr == OFF_TEST;

    assert_lane_keep_R1: assert property (@(posedge clk) disable iff (rst)
        wr_lane |=> ((lane_w ^ $past(lane_w)) & ~$past(bus_wdata[31:16])) == 16'h0);

    assert_lane_take_R1: assert property (@(posedge clk) disable iff (rst)
        wr_lane |=> (lane_w & $past(bus_wdata[31:16])) ==
                    ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16])));

    assert_test_keep_R4: assert property (@(posedge clk) disable iff (rst)
        wr_test |=> ((test_w ^ $past(test_w)) & ~$past(bus_wdata[31:16])) == 16'h0);

    assert_turn_keep_R3: assert property (@(posedge clk) disable iff (rst)
        wr_turn |=> ((turn_w ^ $past(turn_w)) & ~$past(bus_wdata[31:16])) == 16'h0);

    assert_idle_stable_R7: assert property (@(posedge clk) disable iff (rst)
        !(wr_lane || wr_turn || wr_test) |=>
            $stable(lane_w) && $stable(turn_w) && $stable(test_w));

    assert_status_read_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_addr == OFF_STAT) |->
            bus_rdata == {24'h0, phy_test_dout});

    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[31:16] == 16'h0);

    assert_idle_rdata_R6: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && !bus_write) |-> bus_rdata == 32'h0);

    assert_reset_image_R8: assert property (@(posedge clk)
        rst |=> (lane_w == 16'h0 && turn_w == 16'h0 && test_w == 16'h0200));

endmodule

bind phy_ctl_bank phy_ctl_bank_chk #(
    .ADDR_W  (ADDR_W),
    .OFF_TURN(OFF_TURN),
    .OFF_LANE(OFF_LANE),
    .OFF_TEST(OFF_TEST),
    .OFF_STAT(OFF_STAT)
) u_chk (.*);

// File: tb/phy_ctl_bank_test.sv
module phy_ctl_bank_test;

    localparam int CLK_PERIOD = 10;

    localparam logic [15:0] A_TURN = 16'h6224;
    localparam logic [15:0] A_LANE = 16'h6254;
    localparam logic [15:0] A_TEST = 16'h6264;
    localparam logic [15:0] A_STAT = 16'he2a4;
    localparam logic [15:0] A_HOLE = 16'h6244;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    // exp is checked only on reads; req is the requirement number printed on a mismatch
    localparam vec_t VECS [NV] = '{
        '{1'b0, A_LANE, 32'h0,         32'h0000_0000, 8'd8}, // R8 lane reset
        '{1'b0, A_TURN, 32'h0,         32'h0000_0000, 8'd8}, // R8 turn reset
        '{1'b0, A_TEST, 32'h0,         32'h0000_0200, 8'd8}, // R8 test clock at 1
        '{1'b1, A_LANE, 32'hFFFF_1234, 32'h0,         8'd1}, // R1 full mask
        '{1'b0, A_LANE, 32'h0,         32'h0000_1234, 8'd2},
        '{1'b1, A_LANE, 32'h00F0_FFFF, 32'h0,         8'd1}, // R1 one field
        '{1'b0, A_LANE, 32'h0,         32'h0000_12F4, 8'd1},
        '{1'b1, A_LANE, 32'h0000_FFFF, 32'h0,         8'd1}, // R1 empty mask
        '{1'b0, A_LANE, 32'h0,         32'h0000_12F4, 8'd1},
        '{1'b1, A_TURN, 32'hFFFF_FFFF, 32'h0,         8'd3}, // R3 sparse bits
        '{1'b0, A_TURN, 32'h0,         32'h0000_0C0F, 8'd3},
        '{1'b1, A_TURN, 32'h0400_0000, 32'h0,         8'd3},
        '{1'b0, A_TURN, 32'h0,         32'h0000_080F, 8'd3},
        '{1'b1, A_TEST, 32'h0700_0500, 32'h0,         8'd4}, // R4 en/clk/clr
        '{1'b0, A_TEST, 32'h0,         32'h0000_0500, 8'd4},
        '{1'b1, A_TEST, 32'hF8FF_FFAB, 32'h0,         8'd4}, // R4 din + reserved
        '{1'b0, A_TEST, 32'h0,         32'h0000_05AB, 8'd4},
        '{1'b1, A_STAT, 32'hFFFF_0000, 32'h0,         8'd5}, // R5 write ignored
        '{1'b1, A_HOLE, 32'hFFFF_FFFF, 32'h0,         8'd7}, // R7 unmapped write
        '{1'b0, A_HOLE, 32'h0,         32'h0000_0000, 8'd7}  // R7 unmapped read
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  phy_test_dout = 8'hA5;
    logic [3:0]  lane_en, lane_force_rx, lane_force_stop, lane_turn_dis, lane_turn_req;
    logic [1:0]  clk_inv_sel;
    logic [7:0]  test_din;
    logic        test_en, test_clk, test_clr;

    int n_run  = 0;
    int n_fail = 0;
    logic [31:0] rd_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_ctl_bank uut (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .phy_test_dout(phy_test_dout),
        .lane_en(lane_en), .lane_force_rx(lane_force_rx),
        .lane_force_stop(lane_force_stop), .lane_turn_dis(lane_turn_dis),
        .lane_turn_req(lane_turn_req), .clk_inv_sel(clk_inv_sel),
        .test_din(test_din), .test_en(test_en), .test_clk(test_clk),
        .test_clr(test_clr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle; the read value is sampled before the next edge
    task automatic bus_op(input logic v, input logic w, input logic [15:0] a,
                          input logic [31:0] d);
        @(negedge clk);
        bus_valid = v;
        bus_write = w;
        bus_addr  = a;
        bus_wdata = d;
        #1;
        rd_val = bus_rdata;
        @(posedge clk);
        #1;
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_wdata = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R8 reset state at the pins
        #1;
        check("R8 test_clk", {31'b0, test_clk}, 32'h1);
        check("R8 lane pins", {16'b0, lane_turn_dis, lane_force_stop, lane_force_rx, lane_en}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            bus_op(1'b1, VECS[i].wr, VECS[i].addr, VECS[i].data);
            if (!VECS[i].wr)
                check($sformatf("R%0d vec %0d", VECS[i].req, i), rd_val, VECS[i].exp);
        end

        // R2 lane fields at the pins after 0x12F4
        check("R2 lane_en",     {28'b0, lane_en},         32'h4);
        check("R2 force_rx",    {28'b0, lane_force_rx},   32'hF);
        check("R2 force_stop",  {28'b0, lane_force_stop}, 32'h2);
        check("R2 turn_dis",    {28'b0, lane_turn_dis},   32'h1);
        // R3 pins after 0x080F
        check("R3 turn_req",    {28'b0, lane_turn_req},   32'hF);
        check("R3 clk_inv",     {30'b0, clk_inv_sel},     32'h2);
        // R4 pins after 0x05AB
        check("R4 test_din",    {24'b0, test_din},        32'hAB);
        check("R4 en/clk/clr",  {29'b0, test_clr, test_clk, test_en}, 32'h5);

        // R5 status follows the PHY input
        bus_op(1'b1, 1'b0, A_STAT, 32'h0);
        check("R5 status A5", rd_val, 32'h0000_00A5);
        phy_test_dout = 8'h3C;
        bus_op(1'b1, 1'b0, A_STAT, 32'h0);
        check("R5 status 3C", rd_val, 32'h0000_003C);

        // R7 unmapped write did not reach any register
        bus_op(1'b1, 1'b0, A_LANE, 32'h0);
        check("R7 lane kept", rd_val, 32'h0000_12F4);
        bus_op(1'b1, 1'b0, A_TEST, 32'h0);
        check("R7 test kept", rd_val, 32'h0000_05AB);

        // R9 write with valid low
        bus_op(1'b0, 1'b1, A_LANE, 32'hFFFF_0000);
        #1;
        check("R9 lane pins", {28'b0, lane_en}, 32'h4);
        bus_op(1'b1, 1'b0, A_LANE, 32'h0);
        check("R9 lane kept", rd_val, 32'h0000_12F4);

        // R6 idle bus reads zero
        bus_op(1'b0, 1'b0, A_LANE, 32'h0);
        check("R6 idle rdata", rd_val, 32'h0);
        bus_op(1'b1, 1'b1, A_LANE, 32'h0000_0000);
        check("R6 rdata on write", rd_val, 32'h0);

        // R8 reset again mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        bus_op(1'b1, 1'b0, A_TEST, 32'h0);
        check("R8 test after reset", rd_val, 32'h0000_0200);
        bus_op(1'b1, 1'b0, A_TURN, 32'h0);
        check("R8 turn after reset", rd_val, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule